// File: doc/BRIEF.md
# Flash Bank Swap Control Register

This block holds the two-bit address-configuration field that decides which of two program-flash banks appears at the standard address window and which appears at the alternate one. The startup firmware writes the field over a simple register bus while the startup-phase indicator is high. After that phase ends the field is read-only. Application software reads the field back together with a derived active-bank bit. It uses that bit to find the inactive bank, which is the one it may reprogram with new code.

Only two encodings are legal. The field resets to the standard map. If a write lands outside the startup phase, the block answers with a bus error and leaves the field untouched. A watch on the stored value runs at all times and cannot be switched off. If the stored value ever becomes one of the two reserved patterns, for example through an upset, a safety alarm output rises. While the field is illegal, the remap select sent to the flash address decoder stays at the last legal mapping.

Top module: `bank_map_ctrl`

## Requirements
- R1: After reset the field holds the value of parameter RESET_CFG (default 01b). With the default, active_bank is 0 (bank A), inactive_bank is 1, remap_sel is 0, alarm is 0 and bus_err is 0.
- R2: A write (bus_wr high) while startup_i is high stores bus_wdata in the field at that clock edge. The new value is visible from the next cycle.
- R3: A write while startup_i is low leaves the field unchanged. It raises bus_err for exactly the one cycle after the write edge.
- R4: While the stored field is 00b or 11b, alarm is high. It stays high until a legal value is written or reset is applied. Writes of these patterns during startup are stored so that the monitor can be exercised.
- R5: While the field is illegal, remap_sel, active_bank and inactive_bank keep the mapping of the last legal value the field held.
- R6: Field 01b selects the standard map: remap_sel=0, active_bank=0 (A), inactive_bank=1. Field 10b selects the alternate map: remap_sel=1, active_bank=1 (B), inactive_bank=0.
- R7: A write during startup never raises bus_err.
- R8: With RESET_CFG set to 10b, the block leaves reset in the alternate map with alarm low, and stays there while nothing writes it.
- R9: rd_data is {active_bank, field}, with the field in bits 1:0 and the active-bank bit in bit 2, while bus_rd is high. It is all zeros while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startup_i | input | 1 | High while the startup phase runs; enables writes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 2 | Write data for the configuration field |
| rd_data | output | 3 | Read data: {active bank, field} |
| bus_err | output | 1 | Bus error, one cycle after a denied write |
| active_bank | output | 1 | 0 = bank A active, 1 = bank B active |
| inactive_bank | output | 1 | Bank that may be reprogrammed |
| remap_sel | output | 1 | Address remap select to the flash decoder |
| alarm | output | 1 | Safety alarm, high while the field is illegal |

## Verification
The bench instantiates the block twice. The first instance uses the default reset value of 01b and carries the whole vector walk through legal, reserved and denied writes. The second instance is built with RESET_CFG = 10b, which brings the alternate-map reset state and its alarm-free idle within reach without any write. Reserved patterns are injected through startup writes, so the held-mapping behaviour and the alarm clear on a legal write can be observed at the ports.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
    localparam int CFG_W = 2;
    localparam int RD_W  = CFG_W + 1;

    typedef logic [CFG_W-1:0] cfg_t;

    localparam cfg_t CFG_STD = 2'b01;
    localparam cfg_t CFG_ALT = 2'b10;

    typedef struct packed {
        cfg_t cfg;
        logic remap;
        logic err;
    } bmap_state_t;

    function automatic logic cfg_legal(cfg_t c);
        return (c == CFG_STD) || (c == CFG_ALT);
    endfunction

    function automatic logic cfg_remap(cfg_t c);
        return (c == CFG_ALT);
    endfunction
endpackage

// File: rtl/bank_map_guard.sv
module bank_map_guard (
    input  logic startup_i,
    input  logic wr_i,
    output logic accept_o,
    output logic deny_o
);
    always_comb begin
        accept_o = wr_i && startup_i;
        deny_o   = wr_i && !startup_i;
    end
endmodule

// File: rtl/bank_map_decode.sv
module bank_map_decode
    import bank_map_pkg::*;
(
    input  cfg_t cfg_i,
    input  logic held_remap_i,
    output logic legal_o,
    output logic remap_o
);
    always_comb begin
        legal_o = cfg_legal(cfg_i);
        remap_o = legal_o ? cfg_remap(cfg_i) : held_remap_i;
    end
endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
    import bank_map_pkg::*;
#(
    parameter logic [1:0] RESET_CFG = 2'b01
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            startup_i,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [1:0]      bus_wdata,
    output logic [2:0]      rd_data,
    output logic            bus_err,
    output logic            active_bank,
    output logic            inactive_bank,
    output logic            remap_sel,
    output logic            alarm
);
    localparam cfg_t        RST_FIELD = cfg_t'(RESET_CFG);
    localparam bmap_state_t RST_STATE = '{cfg:   RST_FIELD,
                                          remap: cfg_remap(RST_FIELD),
                                          err:   1'b0};

    bmap_state_t st_d, st_q;
    cfg_t        cfg_q;
    logic        wr_ok, wr_deny, legal, remap_now;

    assign cfg_q = st_q.cfg;

    bank_map_guard u_guard (
        .startup_i (startup_i),
        .wr_i      (bus_wr),
        .accept_o  (wr_ok),
        .deny_o    (wr_deny)
    );

    bank_map_decode u_decode (
        .cfg_i        (cfg_q),
        .held_remap_i (st_q.remap),
        .legal_o      (legal),
        .remap_o      (remap_now)
    );

    always_comb begin
        st_d       = st_q;
        st_d.err   = wr_deny;
        st_d.remap = remap_now;
        if (wr_ok) begin
            st_d.cfg = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    always_comb begin
        remap_sel     = remap_now;
        active_bank   = remap_now;
        inactive_bank = ~remap_now;
        alarm         = ~legal;
        bus_err       = st_q.err;
        rd_data       = bus_rd ? {remap_now, cfg_q} : '0;
    end
endmodule

// File: rtl/bank_map_ctrl_chk.sv
module bank_map_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       startup_i,
    input logic       bus_wr,
    input logic [1:0] bus_wdata,
    input logic [1:0] cfg_q,
    input logic       bus_err,
    input logic       remap_sel,
    input logic       alarm
);
    AST_DENIED_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !startup_i) |=> $stable(cfg_q)); // R3
    AST_DENIED_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !startup_i) |=> bus_err); // R3
    AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && !startup_i) |=> !bus_err); // R7
    AST_RESERVED_ALARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && startup_i && (bus_wdata == 2'b00 || bus_wdata == 2'b11)) |=> alarm); // R4
    AST_LEGAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && startup_i && (bus_wdata == 2'b01 || bus_wdata == 2'b10)) |=> !alarm); // R4
    AST_STARTUP_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && startup_i) |=> (cfg_q == $past(bus_wdata))); // R2
    AST_MAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> (remap_sel == $past(remap_sel))); // R5
endmodule

bind bank_map_ctrl bank_map_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .startup_i (startup_i),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .cfg_q     (cfg_q),
    .bus_err   (bus_err),
    .remap_sel (remap_sel),
    .alarm     (alarm)
);

// File: tb/test_bank_map_ctrl.sv
module test_bank_map_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       startup_i = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_wdata = 2'b00;
    logic [2:0] rd_data, rd_data2;
    logic       bus_err, active_bank, inactive_bank, remap_sel, alarm;
    logic       bus_err2, active2, inactive2, remap2, alarm2;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bank_map_ctrl i_bank_map_ctrl (
        .clk(clk), .rst_n(rst_n), .startup_i(startup_i), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .bus_err(bus_err), .active_bank(active_bank), .inactive_bank(inactive_bank),
        .remap_sel(remap_sel), .alarm(alarm)
    );

    bank_map_ctrl #(.RESET_CFG(2'b10)) i_bank_map_ctrl_alt (
        .clk(clk), .rst_n(rst_n), .startup_i(1'b0), .bus_wr(1'b0),
        .bus_rd(bus_rd), .bus_wdata(2'b00), .rd_data(rd_data2),
        .bus_err(bus_err2), .active_bank(active2), .inactive_bank(inactive2),
        .remap_sel(remap2), .alarm(alarm2)
    );

    // {startup, wr, wdata[1:0], field[1:0], active, alarm, err}
    localparam int NV = 10;
    localparam logic [8:0] VEC [NV] = '{
        9'b1_1_10_10_1_0_0,  // R2 R6 alternate map
        9'b1_1_00_00_1_1_0,  // R4 R5 reserved 00 holds B
        9'b1_0_00_00_1_1_0,  // R4 alarm persists
        9'b1_1_01_01_0_0_0,  // R4 cleared, R6 standard map
        9'b1_1_11_11_0_1_0,  // R5 reserved 11 holds A
        9'b1_1_10_10_1_0_0,  // R7 no error in startup
        9'b0_1_01_10_1_0_1,  // R3 denied write
        9'b0_0_01_10_1_0_0,  // R3 error lasts one cycle
        9'b0_1_11_10_1_0_1,  // R3 denied reserved write
        9'b1_1_01_01_0_0_0   // R7 startup again accepts
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_main(input string req, input logic [1:0] f,
                              input logic a, input logic al, input logic e);
        check(req, {2'b0, rd_data, bus_err, active_bank, inactive_bank},
                   {2'b0, a, f, e, a, ~a});
        check(req, {6'b0, remap_sel, alarm}, {6'b0, a, al});
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        bus_rd = 1'b1;
        repeat (3) @(negedge clk);
        check_main("R1", 2'b01, 1'b0, 1'b0, 1'b0);
        check("R8", {4'b0, rd_data2, alarm2}, {4'b0, 3'b110, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        check_main("R1", 2'b01, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            {startup_i, bus_wr, bus_wdata} = VEC[i][8:5];
            @(negedge clk);
            bus_wr = 1'b0;
            check_main($sformatf("R2/R3/R4/R5/R6/R7 vec%0d", i),
                       VEC[i][4:3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R8: alternate-reset instance idle in alternate map
        check("R8", {2'b0, rd_data2, bus_err2, active2, inactive2},
                    {2'b0, 3'b110, 1'b0, 1'b1, 1'b0});
        check("R8", {6'b0, remap2, alarm2}, 8'b10);

        // R9: read strobe low gives zeros
        bus_rd = 1'b0;
        #0.1;
        check("R9", {5'b0, rd_data}, 8'h00);
        check("R9", {5'b0, rd_data2}, 8'h00);
        bus_rd = 1'b1;

        // R4: reset clears an alarm from a reserved value
        startup_i = 1'b1; bus_wr = 1'b1; bus_wdata = 2'b00;
        @(negedge clk);
        bus_wr = 1'b0;
        check_main("R4 reserved before reset", 2'b00, 1'b0, 1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check_main("R4 reset clears alarm", 2'b01, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        startup_i = 1'b0;
        repeat (4) @(negedge clk);
        check_main("R1 idle without writes", 2'b01, 1'b0, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule